// File: doc/BRIEF.md
# Time-of-Day Counter with Atomic Adjust

This block keeps precision time for a chip. On every clock edge where counting is enabled, it adds a 32.32 fixed-point step to a nanosecond accumulator. The upper 32 bits of the step are whole nanoseconds and the lower 32 bits are fractions of a nanosecond. The nominal step is (10^9 << 32) divided by the clock frequency in Hz, and frequency trimming just rewrites the step.

The nanosecond accumulator is kept as an absolute value that runs between a current boundary and a next boundary. When it reaches the next boundary, the seconds count advances and both boundaries move up by the programmed second length (default 1,000,000,000). The reported nanosecond value is the offset past the current boundary.

Software changes time only through staged values committed by a 3-bit opcode. The opcodes are set, increment and decrement. A snapshot port freezes seconds and nanoseconds together in one cycle. An optional event input stamps the time on a chosen pin edge.

Top module: `tod_counter`

## Requirements
- R1: After reset the snapshot reads 0 s / 0 ns, the opcode field reads 0 and `cap_valid` is low.
- R2: While `cfg_run` is high, each clock edge adds `incr_step` to the time, and fractional carries reach the whole nanoseconds. While `cfg_run` is low and no opcode is pending, the time does not change.
- R3: When the absolute nanosecond value reaches the next boundary, seconds advance by 1 in that same edge. The current boundary takes the old next boundary, the next boundary grows by `roll_period`, and the excess nanoseconds are kept, not zeroed.
- R4: Opcode 1 (set) loads the staged absolute nanoseconds, staged fraction, staged seconds and both staged boundaries in one edge. No step is added on that edge.
- R5: Opcode 3 (increment) adds `stg_ns` to the time on the same edge as the normal step. If this carries past the next boundary, seconds go up by 1 on that edge.
- R6: Opcode 4 (decrement) subtracts `stg_ns`. If the offset would go below the current boundary, seconds drop by 1 on that edge, the next boundary takes the old current boundary, and the current boundary falls by `roll_period`. This also holds when the current boundary is 0, using modular arithmetic.
- R7: A write of a nonzero `op_code` while the field is 0 shows that code on `op_field` for exactly one cycle. The field returns to 0 on the edge that applies it. Codes 2, 5, 6 and 7 clear the same way and leave the time unchanged.
- R8: `snap_req` high at an edge loads `snap_sec` and `snap_ns` from one and the same state of the counter.
- R9: With `cfg_cap_en` high, an edge on `evt_pin` is detected after a two-flop synchroniser. `cfg_cap_fall` selects the edge: 0 for rising, 1 for falling. The capture loads `cap_stamp` = {seconds[31:0], nanoseconds[31:0]} and pulses `cap_valid` for one cycle.
- R10: A pin edge of the unselected polarity, or any edge while `cfg_cap_en` is low, produces no `cap_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Counting enable |
| cfg_cap_en | input | 1 | Event capture enable |
| cfg_cap_fall | input | 1 | Capture edge: 0 rising, 1 falling |
| incr_step | input | 32+FRAC_W | Per-cycle 32.32 step |
| roll_period | input | PER_W | Nanoseconds per second |
| stg_ns | input | NS_W | Staged absolute ns (set) or delta (inc/dec) |
| stg_frac | input | FRAC_W | Staged fraction for set |
| stg_sec | input | SEC_W | Staged seconds for set |
| stg_cur | input | NS_W | Staged current boundary |
| stg_nxt | input | NS_W | Staged next boundary |
| op_wr | input | 1 | Opcode write strobe |
| op_code | input | 3 | Opcode: 1 set, 3 increment, 4 decrement |
| op_field | output | 3 | Opcode field readback, self-clearing |
| snap_req | input | 1 | Snapshot request |
| snap_sec | output | SEC_W | Snapshot seconds |
| snap_ns | output | OFF_W | Snapshot nanoseconds |
| evt_pin | input | 1 | External event pin |
| cap_valid | output | 1 | Capture pulse |
| cap_stamp | output | 64 | Captured {seconds, nanoseconds} |

## Verification
The bench builds the block with its default parameters: 64-bit absolute nanoseconds, 48-bit seconds, a 32-bit fraction, a two-stage synchroniser and capture present. It drives a second length of 1000 ns through `roll_period`, so second crossings, carries and borrows happen in tens of cycles. With time frozen, every opcode result is exact. A modular borrow below a zero boundary is reachable, and quarter-nanosecond steps exercise the fractional carry.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int OP_W = 3;
   typedef enum logic [OP_W-1:0] {
      OP_NONE = 3'd0,
      OP_SET  = 3'd1,
      OP_INC  = 3'd3,
      OP_DEC  = 3'd4
   } tod_op_e;
endpackage

// File: rtl/tod_opctl.sv
module tod_opctl
   import tod_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_wr,
   input  logic [OP_W-1:0] op_code,
   output logic [OP_W-1:0] op_field
);
   logic [OP_W-1:0] field_q;

   // A pending code lives for one cycle; it is applied and cleared on the next edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= '0;
      else if (field_q != '0)
         field_q <= '0;
      else if (op_wr)
         field_q <= op_code;
   end

   assign op_field = field_q;
endmodule

// File: rtl/tod_accum.sv
module tod_accum
   import tod_pkg::*;
#(
   parameter int NS_W    = 64,
   parameter int FRAC_W  = 32,
   parameter int SEC_W   = 48,
   parameter int PER_W   = 32,
   parameter int OFF_W   = 32,
   parameter logic [NS_W-1:0] RST_NXT = 64'd1_000_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [31+FRAC_W:0] incr,
   input  logic [PER_W-1:0]  period,
   input  logic [OP_W-1:0]   op,
   input  logic [NS_W-1:0]   stg_ns,
   input  logic [FRAC_W-1:0] stg_frac,
   input  logic [SEC_W-1:0]  stg_sec,
   input  logic [NS_W-1:0]   stg_cur,
   input  logic [NS_W-1:0]   stg_nxt,
   output logic [SEC_W-1:0]  sec_o,
   output logic [OFF_W-1:0]  off_o
);
   localparam int INC_W = 32 + FRAC_W;
   localparam int EXT_W = NS_W + 2;

   logic [NS_W-1:0]   ns_q, cur_q, nxt_q;
   logic [FRAC_W-1:0] frac_q;
   logic [SEC_W-1:0]  sec_q;

   logic [FRAC_W-1:0] frac_add, frac_sum;
   logic              frac_cy;
   logic [NS_W-1:0]   step, off_now, span, delta_inc, delta_dec, ns_nxt, per_ext;
   logic [EXT_W-1:0]  sum;
   logic              do_set, borrow, crossing;

   always_comb begin
      do_set    = (op == OP_SET);
      delta_inc = (op == OP_INC) ? stg_ns : '0;
      delta_dec = (op == OP_DEC) ? stg_ns : '0;
      frac_add  = run ? incr[FRAC_W-1:0] : '0;
      {frac_cy, frac_sum} = {1'b0, frac_q} + {1'b0, frac_add};
      step      = (run ? NS_W'(incr[INC_W-1:FRAC_W]) : '0) + NS_W'(frac_cy);
      per_ext   = NS_W'(period);
      // Offsets relative to the current boundary keep compares correct under modular wrap.
      off_now   = ns_q - cur_q;
      span      = nxt_q - cur_q;
      sum       = EXT_W'(off_now) + EXT_W'(step) + EXT_W'(delta_inc) - EXT_W'(delta_dec);
      borrow    = sum[EXT_W-1];
      crossing  = !borrow && (sum >= EXT_W'(span));
      ns_nxt    = ns_q + step + delta_inc - delta_dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns_q   <= '0;
         frac_q <= '0;
         sec_q  <= '0;
         cur_q  <= '0;
         nxt_q  <= RST_NXT;
      end else if (do_set) begin
         ns_q   <= stg_ns;
         frac_q <= stg_frac;
         sec_q  <= stg_sec;
         cur_q  <= stg_cur;
         nxt_q  <= stg_nxt;
      end else begin
         ns_q   <= ns_nxt;
         frac_q <= frac_sum;
         if (crossing) begin
            sec_q <= sec_q + SEC_W'(1);
            cur_q <= nxt_q;
            nxt_q <= nxt_q + per_ext;
         end else if (borrow) begin
            sec_q <= sec_q - SEC_W'(1);
            nxt_q <= cur_q;
            cur_q <= cur_q - per_ext;
         end
      end
   end

   assign sec_o = sec_q;
   assign off_o = off_now[OFF_W-1:0];
endmodule

// File: rtl/tod_evt_cap.sv
module tod_evt_cap #(
   parameter int SYNC_N = 2,
   parameter int OFF_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_pin,
   input  logic             en,
   input  logic             fall_sel,
   input  logic [31:0]      sec,
   input  logic [OFF_W-1:0] off,
   output logic             valid,
   output logic [63:0]      stamp
);
   logic [SYNC_N-1:0] sync_q;
   logic              prev_q, lvl, hit, valid_q;
   logic [63:0]       stamp_q;

   assign lvl = sync_q[SYNC_N-1];
   assign hit = en && (fall_sel ? (prev_q && !lvl) : (!prev_q && lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         prev_q  <= 1'b0;
         valid_q <= 1'b0;
         stamp_q <= '0;
      end else begin
         sync_q  <= {sync_q[SYNC_N-2:0], evt_pin};
         prev_q  <= lvl;
         valid_q <= hit;
         if (hit)
            stamp_q <= {sec, 32'(off)};
      end
   end

   assign valid = valid_q;
   assign stamp = stamp_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int NS_W            = 64,
   parameter int FRAC_W          = 32,
   parameter int SEC_W           = 48,
   parameter int PER_W           = 32,
   parameter int OFF_W           = 32,
   parameter int SYNC_N          = 2,
   parameter bit CAPTURE_PRESENT = 1'b1,
   parameter logic [NS_W-1:0] RST_NXT = 64'd1_000_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_run,
   input  logic               cfg_cap_en,
   input  logic               cfg_cap_fall,
   input  logic [31+FRAC_W:0] incr_step,
   input  logic [PER_W-1:0]   roll_period,
   input  logic [NS_W-1:0]    stg_ns,
   input  logic [FRAC_W-1:0]  stg_frac,
   input  logic [SEC_W-1:0]   stg_sec,
   input  logic [NS_W-1:0]    stg_cur,
   input  logic [NS_W-1:0]    stg_nxt,
   input  logic               op_wr,
   input  logic [2:0]         op_code,
   output logic [2:0]         op_field,
   input  logic               snap_req,
   output logic [SEC_W-1:0]   snap_sec,
   output logic [OFF_W-1:0]   snap_ns,
   input  logic               evt_pin,
   output logic               cap_valid,
   output logic [63:0]        cap_stamp
);
   if (FRAC_W < 1 || FRAC_W > 32) begin : g_bad_frac
      $error("tod_counter: FRAC_W must be 1..32");
   end
   if (NS_W < OFF_W || NS_W < PER_W) begin : g_bad_ns
      $error("tod_counter: NS_W must cover OFF_W and PER_W");
   end
   if (SEC_W < 32 || OFF_W > 32) begin : g_bad_stamp
      $error("tod_counter: stamp needs SEC_W >= 32 and OFF_W <= 32");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("tod_counter: SYNC_N must be at least 2");
   end

   logic [SEC_W-1:0] live_sec;
   logic [OFF_W-1:0] live_off;
   logic [SEC_W-1:0] snap_sec_q;
   logic [OFF_W-1:0] snap_ns_q;

   tod_opctl u_opctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_wr    (op_wr),
      .op_code  (op_code),
      .op_field (op_field)
   );

   tod_accum #(
      .NS_W(NS_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W),
      .PER_W(PER_W), .OFF_W(OFF_W), .RST_NXT(RST_NXT)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (cfg_run),
      .incr     (incr_step),
      .period   (roll_period),
      .op       (op_field),
      .stg_ns   (stg_ns),
      .stg_frac (stg_frac),
      .stg_sec  (stg_sec),
      .stg_cur  (stg_cur),
      .stg_nxt  (stg_nxt),
      .sec_o    (live_sec),
      .off_o    (live_off)
   );

   // Both halves load from one register state, so a rollover cannot split them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_sec_q <= '0;
         snap_ns_q  <= '0;
      end else if (snap_req) begin
         snap_sec_q <= live_sec;
         snap_ns_q  <= live_off;
      end
   end
   assign snap_sec = snap_sec_q;
   assign snap_ns  = snap_ns_q;

   if (CAPTURE_PRESENT) begin : g_cap
      tod_evt_cap #(.SYNC_N(SYNC_N), .OFF_W(OFF_W)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_pin  (evt_pin),
         .en       (cfg_cap_en),
         .fall_sel (cfg_cap_fall),
         .sec      (live_sec[31:0]),
         .off      (live_off),
         .valid    (cap_valid),
         .stamp    (cap_stamp)
      );
   end else begin : g_nocap
      assign cap_valid = 1'b0;
      assign cap_stamp = '0;
   end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
   parameter int SEC_W = 48,
   parameter int OFF_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_run,
   input logic             cfg_cap_en,
   input logic [2:0]       op_field,
   input logic             snap_req,
   input logic [SEC_W-1:0] snap_sec,
   input logic [OFF_W-1:0] snap_ns,
   input logic [SEC_W-1:0] live_sec,
   input logic [OFF_W-1:0] live_off,
   input logic             cap_valid
);
   assert_field_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_field != 3'd0) |=> (op_field == 3'd0));

   assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_run && op_field == 3'd0) |=> ($stable(live_sec) && $stable(live_off)));

   assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_run && op_field == 3'd0) |=>
         (live_sec == $past(live_sec) || live_sec == $past(live_sec) + SEC_W'(1)));

   assert_snap_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (snap_sec == $past(live_sec) && snap_ns == $past(live_off)));

   assert_cap_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cap_en |=> !cap_valid);

   assert_cap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> !cap_valid);
endmodule

bind tod_counter tod_counter_chk #(.SEC_W(SEC_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_cap_en(cfg_cap_en),
   .op_field(op_field), .snap_req(snap_req), .snap_sec(snap_sec), .snap_ns(snap_ns),
   .live_sec(live_sec), .live_off(live_off), .cap_valid(cap_valid)
);

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;
   logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, cap_en = 1'b0, cap_fall = 1'b0;
   logic        op_wr = 1'b0, snap_req = 1'b0, evt = 1'b0;
   logic [63:0] incr = 64'h0000000A_00000000;
   logic [31:0] per = 32'd1000;
   logic [63:0] s_ns = '0, s_cur = '0, s_nxt = '0;
   logic [31:0] s_frac = '0;
   logic [47:0] s_sec = '0;
   logic [2:0]  opc = '0;
   logic [2:0]  op_field;
   logic [47:0] snap_sec;
   logic [31:0] snap_ns;
   logic        cap_valid;
   logic [63:0] cap_stamp;
   int          n_chk = 0, n_bad = 0;
   logic [63:0] gs, gn;

   // {pad, code, delta, expected sec, expected ns}, each starting from 5 s / 250 ns
   localparam logic [63:0] VEC [8] = '{
      {8'h0, 8'd3, 16'd100, 16'd5, 16'd350},
      {8'h0, 8'd3, 16'd800, 16'd6, 16'd50},
      {8'h0, 8'd3, 16'd750, 16'd6, 16'd0},
      {8'h0, 8'd4, 16'd100, 16'd5, 16'd150},
      {8'h0, 8'd4, 16'd300, 16'd4, 16'd950},
      {8'h0, 8'd4, 16'd250, 16'd5, 16'd0},
      {8'h0, 8'd2, 16'd100, 16'd5, 16'd250},
      {8'h0, 8'd7, 16'd400, 16'd5, 16'd250}
   };

   tod_counter u_tod_counter (
      .clk(clk), .rst_n(rst_n), .cfg_run(run), .cfg_cap_en(cap_en), .cfg_cap_fall(cap_fall),
      .incr_step(incr), .roll_period(per), .stg_ns(s_ns), .stg_frac(s_frac), .stg_sec(s_sec),
      .stg_cur(s_cur), .stg_nxt(s_nxt), .op_wr(op_wr), .op_code(opc), .op_field(op_field),
      .snap_req(snap_req), .snap_sec(snap_sec), .snap_ns(snap_ns), .evt_pin(evt),
      .cap_valid(cap_valid), .cap_stamp(cap_stamp)
   );

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic do_op(input logic [2:0] c, input bit chk_field);
      @(negedge clk); opc = c; op_wr = 1'b1;
      @(negedge clk); op_wr = 1'b0;
      if (chk_field) check("R7 field readback", 64'(op_field), 64'(c));
      @(negedge clk);
      if (chk_field) check("R7 field cleared", 64'(op_field), 64'd0);
   endtask

   task automatic set_time(input logic [47:0] sec, input logic [63:0] ns,
                           input logic [63:0] cur, input logic [63:0] nxt, input logic [31:0] frac);
      s_sec = sec; s_ns = ns; s_cur = cur; s_nxt = nxt; s_frac = frac;
      do_op(3'd1, 1'b0);
   endtask

   task automatic take_snap(output logic [63:0] sec, output logic [63:0] ns);
      @(negedge clk); snap_req = 1'b1;
      @(negedge clk); snap_req = 1'b0;
      sec = 64'(snap_sec); ns = 64'(snap_ns);
   endtask

   task automatic run_for(input int k);
      @(negedge clk); run = 1'b1;
      repeat (k) @(negedge clk);
      run = 1'b0;
   endtask

   task automatic expect_cap(input string tag, input bit want, input logic [63:0] stamp);
      bit seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (cap_valid && !seen) begin
            seen = 1'b1;
            if (want) check({tag, " stamp"}, cap_stamp, stamp);
            @(negedge clk);
            if (want) check("R9 one-cycle pulse", 64'(cap_valid), 64'd0);
         end
      end
      check({tag, " seen"}, 64'(seen), 64'(want));
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog got=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 op field", 64'(op_field), 64'd0);
      check("R1 cap_valid", 64'(cap_valid), 64'd0);
      take_snap(gs, gn);
      check("R1 sec", gs, 64'd0);
      check("R1 ns", gn, 64'd0);

      // Table walk: R5 increment, R6 decrement, R7 opcode handling
      for (int i = 0; i < 8; i++) begin
         set_time(48'd5, 64'd5250, 64'd5000, 64'd6000, 32'd0);
         s_ns = 64'(VEC[i][47:32]);
         do_op(VEC[i][50:48], 1'b1);
         take_snap(gs, gn);
         check($sformatf("R5/R6/R7 vec%0d sec", i), gs, 64'(VEC[i][31:16]));
         check($sformatf("R5/R6/R7 vec%0d ns", i), gn, 64'(VEC[i][15:0]));
      end

      // R5 carry moves the next boundary: 6 s/50 ns then +950 reaches 7 s
      set_time(48'd5, 64'd5250, 64'd5000, 64'd6000, 32'd0);
      s_ns = 64'd800; do_op(3'd3, 1'b0);
      s_ns = 64'd950; do_op(3'd3, 1'b0);
      take_snap(gs, gn);
      check("R5 second carry sec", gs, 64'd7);
      check("R5 second carry ns", gn, 64'd0);

      // R6 borrow below a zero boundary, then R5 climbs back
      set_time(48'd3, 64'd100, 64'd0, 64'd1000, 32'd0);
      s_ns = 64'd300; do_op(3'd4, 1'b0);
      take_snap(gs, gn);
      check("R6 zero-boundary borrow sec", gs, 64'd2);
      check("R6 zero-boundary borrow ns", gn, 64'd800);
      s_ns = 64'd200; do_op(3'd3, 1'b0);
      take_snap(gs, gn);
      check("R6 recover sec", gs, 64'd3);
      check("R6 recover ns", gn, 64'd0);

      // R2/R3 counting with a 10 ns step
      incr = 64'h0000000A_00000000;
      set_time(48'd5, 64'd5990, 64'd5000, 64'd6000, 32'd0);
      run_for(1);
      take_snap(gs, gn);
      check("R3 cross sec", gs, 64'd6);
      check("R3 cross ns", gn, 64'd0);
      run_for(100);
      take_snap(gs, gn);
      check("R3 next boundary sec", gs, 64'd7);
      check("R3 next boundary ns", gn, 64'd0);
      run_for(37);
      repeat (5) @(negedge clk);
      take_snap(gs, gn);
      check("R2 run then hold ns", gn, 64'd370);

      // R2 fractional steps, R4 staged fraction
      incr = 64'h00000000_40000000;
      set_time(48'd5, 64'd5000, 64'd5000, 64'd6000, 32'd0);
      run_for(8);
      take_snap(gs, gn);
      check("R2 quarter steps", gn, 64'd2);
      incr = 64'h00000001_C0000000;
      run_for(4);
      take_snap(gs, gn);
      check("R2 1.75 ns steps", gn, 64'd9);
      incr = 64'h00000000_40000000;
      set_time(48'd9, 64'd5000, 64'd5000, 64'd6000, 32'hC0000000);
      run_for(1);
      take_snap(gs, gn);
      check("R4 staged fraction carry", gn, 64'd1);
      check("R4 staged sec", gs, 64'd9);

      // R5 increment concurrent with counting
      incr = 64'h0000000A_00000000;
      set_time(48'd5, 64'd5500, 64'd5000, 64'd6000, 32'd0);
      @(negedge clk); run = 1'b1; s_ns = 64'd20; opc = 3'd3; op_wr = 1'b1;
      @(negedge clk); op_wr = 1'b0;
      @(negedge clk); run = 1'b0; snap_req = 1'b1;
      @(negedge clk); snap_req = 1'b0;
      check("R5 inc with counting ns", 64'(snap_ns), 64'd540);

      // R9 capture on both polarities, R10 suppression
      set_time(48'd5, 64'd5250, 64'd5000, 64'd6000, 32'd0);
      cap_en = 1'b1; cap_fall = 1'b0;
      @(negedge clk); evt = 1'b1;
      expect_cap("R9 rising", 1'b1, {32'd5, 32'd250});
      s_ns = 64'd100; do_op(3'd3, 1'b0);
      cap_fall = 1'b1;
      @(negedge clk); evt = 1'b0;
      expect_cap("R9 falling", 1'b1, {32'd5, 32'd350});
      @(negedge clk); evt = 1'b1;
      expect_cap("R10 wrong edge", 1'b0, 64'd0);
      cap_en = 1'b0;
      @(negedge clk); evt = 1'b0;
      expect_cap("R10 disabled", 1'b0, 64'd0);

      finish_run();
   end
endmodule